// File: doc/BRIEF.md
# Half-Bridge Gate Command Sequencer

This block takes the high-side and low-side switching commands for a power half-bridge and turns them into the enable signals for two isolated gate driver channels. It also tells the isolated gate supply when to run at full capability. After reset it holds both gates off and keeps the supply request low for a fixed startup interval. The interval is derived from the system clock frequency. When the interval ends with no fault present, the supply request goes high and switching is allowed.

Three drive modes are selected by a static mode input. The protected half-bridge mode inserts a configurable dead time whenever conduction passes from one switch to the other, and never lets both switches conduct at once. The independent mode passes each command straight through with no protection. The concurrent mode drives both switches from the high-side command, which is meant for avalanche or double-pulse testing. A fault from either driver channel switches both gates off and drops the supply request. The shutdown is latched and shown on a status output until the next reset.

Top module: `hb_gate_sequencer`

## Requirements
- R1: From reset release, `gate_hi_o`, `gate_lo_o` and `pwr_full_o` stay 0 for the first STARTUP_CYCLES-1 rising edges, where STARTUP_CYCLES = CLK_FREQ_HZ/1e6 × STARTUP_US. All outputs are 0 while `rst_n` is low.
- R2: With no fault seen since reset, `pwr_full_o` becomes 1 at rising edge STARTUP_CYCLES after release, and a gate may turn on from the following edge. If a fault was seen during startup, `pwr_full_o` stays 0.
- R3: Mode encoding: 2'b00 and 2'b11 select protected half-bridge, 2'b01 independent, 2'b10 concurrent. In protected half-bridge mode the two gates are never both 1.
- R4: In protected half-bridge mode the dead time is D = (`dt_sel_i`+1) × DT_STEP cycles. When one gate turns off and the other is requested, both gates are 0 for exactly D cycles before the requested gate turns on.
- R5: In independent mode each gate equals its own command sampled at the previous rising edge, with no dead time and no blocking.
- R6: In concurrent mode both gates equal `cmd_hi_i` sampled at the previous rising edge, and `cmd_lo_i` has no effect.
- R7: In protected half-bridge mode, while both commands are 1 both gates are 0. Once only one command remains, that gate turns on after the dead time.
- R8: Pulses are not lost or narrowed apart from dead time. A one-cycle command pulse in independent mode appears as a one-cycle gate pulse. An L-cycle pulse in half-bridge mode, with the opposite gate off for at least D cycles, gives an L-cycle gate pulse.
- R9: `flt_hi_i` or `flt_lo_i` high at a rising edge, in any mode or phase, forces both gates and `pwr_full_o` to 0 from that edge.
- R10: `fault_o` is 1 from the edge that samples a fault and for as long as the shutdown lasts.
- R11: The shutdown is latched. Clearing the fault inputs leaves gates off, `pwr_full_o` 0 and `fault_o` 1. Only `rst_n` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Static drive mode select |
| dt_sel_i | input | DT_SEL_W | Static dead-time select code |
| cmd_hi_i | input | 1 | High-side switching command |
| cmd_lo_i | input | 1 | Low-side switching command |
| flt_hi_i | input | 1 | Fault report from high-side driver |
| flt_lo_i | input | 1 | Fault report from low-side driver |
| gate_hi_o | output | 1 | High-side gate enable |
| gate_lo_o | output | 1 | Low-side gate enable |
| pwr_full_o | output | 1 | Gate supply full-capability request |
| fault_o | output | 1 | Latched fault shutdown status |

## Verification
Every output is registered, so a command or fault sampled at one rising edge shows at the outputs right after that edge. In protected mode a hand-over takes D+1 edges from the command change to the new gate rising. The startup release lands exactly on edge STARTUP_CYCLES after reset. The bench drives inputs at the falling edge, samples 1 ns after each rising edge and counts edges from the change. This lets it check every cycle of the startup window and of each dead-time window against those counts, for all four dead-time codes.

// File: rtl/hb_seq_pkg.sv
package hb_seq_pkg;

   typedef enum logic [1:0] {
      MODE_HB     = 2'b00,
      MODE_IND    = 2'b01,
      MODE_CONC   = 2'b10,
      MODE_HB_ALT = 2'b11
   } drive_mode_e;

   localparam int N_CH   = 2;
   localparam int CH_HI  = 0;
   localparam int CH_LO  = 1;

   function automatic logic is_protected(drive_mode_e m);
      return (m == MODE_HB) || (m == MODE_HB_ALT);
   endfunction

endpackage

// File: rtl/hb_startup_timer.sv
module hb_startup_timer #(
   parameter int CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic done_o
);
   localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES + 1) : 1;

   if (CYCLES < 1) begin : g_bad_cycles
      $error("hb_startup_timer: CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (!done_q) begin
         if (cnt_q == CNT_W'(CYCLES - 1)) done_q <= 1'b1;
         else                             cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign done_o = done_q;

   // R2
   done_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> done_q);

endmodule

// File: rtl/hb_fault_latch.sv
module hb_fault_latch #(
   parameter int N_IN = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_IN-1:0] flt_i,
   output logic            trip_o,
   output logic            fault_o
);
   if (N_IN < 1) begin : g_bad_n
      $error("hb_fault_latch: N_IN must be at least 1");
   end

   logic fault_q;

   assign trip_o = |flt_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      fault_q <= 1'b0;
      else if (trip_o) fault_q <= 1'b1;
   end

   assign fault_o = fault_q;

   // R11
   fault_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_q |=> fault_q);

   // R10
   fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trip_o |=> fault_q);

endmodule

// File: rtl/hb_gate_chan.sv
module hb_gate_chan
   import hb_seq_pkg::*;
#(
   parameter int CNT_W   = 4,
   parameter int CNT_MAX = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  drive_mode_e      mode_i,
   input  logic             cmd_self_i,
   input  logic             cmd_other_i,
   input  logic             cmd_conc_i,
   input  logic             other_gate_i,
   input  logic [CNT_W-1:0] other_off_i,
   input  logic [CNT_W-1:0] dead_i,
   output logic             gate_o,
   output logic [CNT_W-1:0] off_cnt_o
);
   if (CNT_MAX >= (1 << CNT_W)) begin : g_bad_w
      $error("hb_gate_chan: CNT_W too small for CNT_MAX");
   end

   logic             gate_q;
   logic [CNT_W-1:0] off_q;
   logic             hb_req;
   logic             hb_clear;
   logic             want;

   assign hb_req   = cmd_self_i & ~cmd_other_i;
   assign hb_clear = ~other_gate_i & (other_off_i >= (dead_i - CNT_W'(1)));

   always_comb begin
      unique case (mode_i)
         MODE_IND:  want = cmd_self_i;
         MODE_CONC: want = cmd_conc_i;
         default:   want = hb_req & hb_clear;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q <= 1'b0;
         off_q  <= CNT_W'(CNT_MAX);
      end else begin
         gate_q <= run_i & want;
         if (gate_q)                        off_q <= '0;
         else if (off_q != CNT_W'(CNT_MAX)) off_q <= off_q + 1'b1;
      end
   end

   assign gate_o    = gate_q;
   assign off_cnt_o = off_q;

   // R4
   no_early_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(gate_q) && $past(is_protected(mode_i))) |-> $past(!other_gate_i));

   // R7
   both_req_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_protected(mode_i) && cmd_self_i && cmd_other_i) |=> !gate_q);

endmodule

// File: rtl/hb_gate_sequencer.sv
module hb_gate_sequencer
   import hb_seq_pkg::*;
#(
   parameter int CLK_FREQ_HZ = 125_000_000,
   parameter int STARTUP_US  = 500_000,
   parameter int DT_SEL_W    = 3,
   parameter int DT_STEP     = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          mode_i,
   input  logic [DT_SEL_W-1:0] dt_sel_i,
   input  logic                cmd_hi_i,
   input  logic                cmd_lo_i,
   input  logic                flt_hi_i,
   input  logic                flt_lo_i,
   output logic                gate_hi_o,
   output logic                gate_lo_o,
   output logic                pwr_full_o,
   output logic                fault_o
);
   localparam int STARTUP_CYCLES = (CLK_FREQ_HZ / 1_000_000) * STARTUP_US;
   localparam int DT_MAX         = (1 << DT_SEL_W) * DT_STEP;
   localparam int CNT_W          = $clog2(DT_MAX + 1);

   if (CLK_FREQ_HZ < 1_000_000) begin : g_bad_clk
      $error("hb_gate_sequencer: CLK_FREQ_HZ must be at least 1 MHz");
   end
   if (STARTUP_US < 1) begin : g_bad_start
      $error("hb_gate_sequencer: STARTUP_US must be at least 1");
   end
   if (DT_SEL_W < 1 || DT_SEL_W > 6) begin : g_bad_sel
      $error("hb_gate_sequencer: DT_SEL_W out of range");
   end
   if (DT_STEP < 1) begin : g_bad_step
      $error("hb_gate_sequencer: DT_STEP must be at least 1");
   end

   drive_mode_e      mode;
   logic             start_done;
   logic             trip;
   logic             fault_q;
   logic             run;
   logic [CNT_W-1:0] dead;
   logic [N_CH-1:0]  cmd_v;
   logic [N_CH-1:0]  gate_v;
   logic [CNT_W-1:0] off_v [N_CH];

   assign mode  = drive_mode_e'(mode_i);
   assign dead  = CNT_W'((int'(dt_sel_i) + 1) * DT_STEP);
   assign cmd_v[CH_HI] = cmd_hi_i;
   assign cmd_v[CH_LO] = cmd_lo_i;

   hb_startup_timer #(.CYCLES(STARTUP_CYCLES)) i_start (
      .clk    (clk),
      .rst_n  (rst_n),
      .done_o (start_done)
   );

   hb_fault_latch #(.N_IN(N_CH)) i_fault (
      .clk     (clk),
      .rst_n   (rst_n),
      .flt_i   ({flt_lo_i, flt_hi_i}),
      .trip_o  (trip),
      .fault_o (fault_q)
   );

   assign run = start_done & ~fault_q & ~trip;

   for (genvar g = 0; g < N_CH; g++) begin : g_chan
      localparam int OTH = N_CH - 1 - g;
      hb_gate_chan #(.CNT_W(CNT_W), .CNT_MAX(DT_MAX)) i_chan (
         .clk          (clk),
         .rst_n        (rst_n),
         .run_i        (run),
         .mode_i       (mode),
         .cmd_self_i   (cmd_v[g]),
         .cmd_other_i  (cmd_v[OTH]),
         .cmd_conc_i   (cmd_v[CH_HI]),
         .other_gate_i (gate_v[OTH]),
         .other_off_i  (off_v[OTH]),
         .dead_i       (dead),
         .gate_o       (gate_v[g]),
         .off_cnt_o    (off_v[g])
      );
   end

   assign gate_hi_o  = gate_v[CH_HI];
   assign gate_lo_o  = gate_v[CH_LO];
   assign pwr_full_o = start_done & ~fault_q;
   assign fault_o    = fault_q;

   // R3
   no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(is_protected(mode)) |-> !(gate_hi_o && gate_lo_o));

   // R9
   fault_gates_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_hi_i || flt_lo_i) |=> (!gate_hi_o && !gate_lo_o && !pwr_full_o));

   // R1
   gate_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_hi_o || gate_lo_o) |-> pwr_full_o);

   // R10
   status_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> !pwr_full_o);

   // R5
   indep_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode == MODE_IND) && $past(pwr_full_o) && !$past(trip))
         |-> (gate_hi_o == $past(cmd_hi_i) && gate_lo_o == $past(cmd_lo_i)));

   // R6
   conc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode == MODE_CONC) && $past(pwr_full_o) && !$past(trip))
         |-> (gate_hi_o == $past(cmd_hi_i) && gate_lo_o == $past(cmd_hi_i)));

endmodule

// File: tb/test_hb_gate_sequencer.sv
`timescale 1ns/1ps
module test_hb_gate_sequencer;
   localparam int CLK_HZ = 1_000_000;
   localparam int ST_US  = 40;
   localparam int SEL_W  = 2;
   localparam int STEP   = 2;
   localparam int S      = (CLK_HZ / 1_000_000) * ST_US;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       mode = 2'b01;
   logic [SEL_W-1:0] dt_sel = '0;
   logic             cmd_hi = 1'b0, cmd_lo = 1'b0;
   logic             flt_hi = 1'b0, flt_lo = 1'b0;
   logic             gate_hi, gate_lo, pwr_full, fault;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   hb_gate_sequencer #(.CLK_FREQ_HZ(CLK_HZ), .STARTUP_US(ST_US),
                       .DT_SEL_W(SEL_W), .DT_STEP(STEP)) i_hb_gate_sequencer (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .dt_sel_i(dt_sel),
      .cmd_hi_i(cmd_hi), .cmd_lo_i(cmd_lo), .flt_hi_i(flt_hi), .flt_lo_i(flt_lo),
      .gate_hi_o(gate_hi), .gate_lo_o(gate_lo), .pwr_full_o(pwr_full), .fault_o(fault));

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(string req, string what, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic restart();
      @(negedge clk);
      rst_n = 1'b0; flt_hi = 1'b0; flt_lo = 1'b0; cmd_hi = 1'b0; cmd_lo = 1'b0;
      step(2);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(8 * 150_000);
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int d, cnt;
      step(3);
      chk("R1", "gate_hi in reset", gate_hi, 1'b0);
      chk("R1", "pwr_full in reset", pwr_full, 1'b0);
      chk("R10", "fault in reset", fault, 1'b0);
      @(negedge clk);
      rst_n = 1'b1; cmd_hi = 1'b1;
      for (int k = 1; k < S; k++) begin
         step(1);
         chk("R1", "pwr_full in startup", pwr_full, 1'b0);
         chk("R1", "gate_hi in startup", gate_hi, 1'b0);
      end
      step(1);
      chk("R2", "pwr_full at end of startup", pwr_full, 1'b1);
      chk("R2", "gate_hi at end of startup", gate_hi, 1'b0);
      step(1);
      chk("R2", "gate_hi after startup", gate_hi, 1'b1);

      // R5 independent sweep
      for (int v = 0; v < 4; v++) begin
         @(negedge clk); cmd_hi = v[0]; cmd_lo = v[1];
         step(1);
         chk("R5", "indep gate_hi", gate_hi, v[0]);
         chk("R5", "indep gate_lo", gate_lo, v[1]);
      end
      // R8 one-cycle pulses
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); cmd_hi = i[0]; cmd_lo = ~i[0];
         step(1);
         chk("R8", "indep pulse gate_hi", gate_hi, i[0]);
         chk("R8", "indep pulse gate_lo", gate_lo, ~i[0]);
      end
      // R6 concurrent sweep
      @(negedge clk); mode = 2'b10;
      for (int v = 0; v < 4; v++) begin
         @(negedge clk); cmd_hi = v[0]; cmd_lo = v[1];
         step(1);
         chk("R6", "conc gate_hi", gate_hi, v[0]);
         chk("R6", "conc gate_lo", gate_lo, v[0]);
      end

      // R4 dead-time sweep over all codes
      @(negedge clk); mode = 2'b00; cmd_hi = 0; cmd_lo = 0;
      for (int sel = 0; sel < 4; sel++) begin
         d = (sel + 1) * STEP;
         @(negedge clk); dt_sel = SEL_W'(sel); cmd_hi = 0; cmd_lo = 0;
         step(d + 4);
         @(negedge clk); cmd_lo = 1;
         step(1);
         chk("R4", "lo on after long idle", gate_lo, 1'b1);
         @(negedge clk); cmd_lo = 0; cmd_hi = 1;
         for (int k = 1; k <= d + 2; k++) begin
            step(1);
            chk("R4", "hi during handover", gate_hi, logic'(k >= d + 1));
            chk("R3", "lo off during handover", gate_lo, 1'b0);
         end
         @(negedge clk); cmd_hi = 0; cmd_lo = 1;
         for (int k = 1; k <= d + 2; k++) begin
            step(1);
            chk("R4", "lo during handover", gate_lo, logic'(k >= d + 1));
            chk("R3", "hi off during handover", gate_hi, 1'b0);
         end
      end

      // R8 half-bridge pulse width kept
      @(negedge clk); dt_sel = '0; cmd_hi = 0; cmd_lo = 0;
      step(12);
      @(negedge clk); cmd_hi = 1;
      cnt = 0;
      for (int i = 0; i < 8; i++) begin
         if (i == 3) cmd_hi = 0;
         step(1);
         cnt += int'(gate_hi);
      end
      chk("R8", "hb pulse width is 3", logic'(cnt == 3), 1'b1);

      // R7 both requested
      @(negedge clk); cmd_hi = 1;
      step(2);
      chk("R7", "hi on before overlap", gate_hi, 1'b1);
      @(negedge clk); cmd_lo = 1;
      for (int k = 0; k < 4; k++) begin
         step(1);
         chk("R7", "hi off while both requested", gate_hi, 1'b0);
         chk("R7", "lo off while both requested", gate_lo, 1'b0);
      end
      @(negedge clk); cmd_hi = 0;
      step(1);
      chk("R7", "lo on once alone", gate_lo, 1'b1);

      // R3 alternate protected code
      @(negedge clk); mode = 2'b11; cmd_hi = 1; cmd_lo = 1;
      step(2);
      chk("R3", "code 11 blocks both hi", gate_hi, 1'b0);
      chk("R3", "code 11 blocks both lo", gate_lo, 1'b0);

      // R9 R10 R11 fault shutdown
      @(negedge clk); mode = 2'b01;
      step(2);
      chk("R5", "both on before fault", gate_hi & gate_lo, 1'b1);
      @(negedge clk); flt_lo = 1;
      step(1);
      chk("R9", "gate_hi after fault", gate_hi, 1'b0);
      chk("R9", "gate_lo after fault", gate_lo, 1'b0);
      chk("R9", "pwr_full after fault", pwr_full, 1'b0);
      chk("R10", "fault_o after fault", fault, 1'b1);
      @(negedge clk); flt_lo = 0;
      step(6);
      chk("R11", "gate_hi stays off", gate_hi, 1'b0);
      chk("R11", "pwr_full stays low", pwr_full, 1'b0);
      chk("R11", "fault_o held", fault, 1'b1);

      // R2 fault during startup blocks release
      restart();
      step(1);
      chk("R11", "fault cleared by reset", fault, 1'b0);
      cmd_hi = 1;
      step(5);
      @(negedge clk); flt_hi = 1;
      step(1);
      chk("R10", "fault_o in startup fault", fault, 1'b1);
      @(negedge clk); flt_hi = 0;
      step(S + 5);
      chk("R2", "pwr_full after faulted startup", pwr_full, 1'b0);
      chk("R2", "gate_hi after faulted startup", gate_hi, 1'b0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule